// File: doc/BRIEF.md
# Bridge I/O and Configuration Cycle Generator

This block sits on the local-bus side of a bus bridge. It turns local master accesses that fall inside a programmable window into single PCI I/O or configuration transactions, which it hands to a PCI protocol engine through a request/acknowledge pair. A local access is claimed when the masked local address matches the masked window base. The range mask holds the inverted window size. Three control bits must all be set before anything is claimed: master enable, I/O space enable and direct I/O access enable.

The top bit of a programmable configuration-address word selects the mode. When that bit is clear, the block forms an I/O address from a remap base and the local offset, and it can optionally clear the upper half of that address. When the bit is set, the block builds a Type 0 or Type 1 configuration address from the register. For Type 0, the device number becomes a single IDSEL bit. A local burst is broken into one PCI transaction per data word. A write is acknowledged to the local master without waiting for the PCI side. A read holds the local ready signal until the PCI side returns the data word.

Top module: `iocfg_bridge`

## Requirements
- R1: The first word of a local access is claimed only when ((lb_addr XOR win_base) AND win_mask) is zero. An unclaimed access raises neither pci_req nor lb_ready.
- R2: No access is claimed unless en_master, en_io_space and en_dm_io are all 1. Clearing any one of them leaves pci_req and lb_ready low.
- R3: When cfg_addr_reg[31] is 0, the block forms an I/O address: (io_remap AND win_mask) OR (word address AND NOT win_mask). Bits [1:0] are then replaced with the index of the lowest set byte enable, or 00 if no byte enable is set. The command is 0010 for a read and 0011 for a write.
- R4: In I/O mode with io_hi_clear = 1, pci_addr[31:16] is zero.
- R5: In configuration mode with cfg_addr_reg[1:0] = 00 (Type 0), pci_addr[10:0] equals cfg_addr_reg[10:0]. Let d be the device number in cfg_addr_reg[15:11]. When d ≤ 20, exactly bit d+11 is set within pci_addr[31:11]. When d > 20, pci_addr[31:11] is all zero.
- R6: In configuration mode with cfg_addr_reg[1:0] ≠ 00 (Type 1), pci_addr[23:0] equals cfg_addr_reg[23:0] and pci_addr[31:24] is zero.
- R7: The configuration command is 1010 for a read and 1011 for a write.
- R8: pci_be equals the lb_be of the word that was claimed. pci_wdata equals that word's lb_wdata.
- R9: A write is acknowledged by a one-cycle lb_ready pulse in the first cycle in which pci_req is high. This does not depend on pci_ack.
- R10: While a read is outstanding, lb_ready stays low. In the cycle after pci_ack, lb_ready pulses for one cycle and lb_rdata holds the pci_rdata that was sampled with pci_ack.
- R11: A burst issues one PCI transaction per word until a word with lb_last set is claimed. Later words in a burst skip the window decode. In I/O mode, each later word's address advances by 4 from the first word's address, and lb_addr is ignored. In configuration mode, every word uses the register address.
- R12: After reset, pci_req and lb_ready are low. Once raised, pci_req and all request fields hold steady until pci_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_master | input | 1 | Master enable control bit |
| en_io_space | input | 1 | I/O space enable control bit |
| en_dm_io | input | 1 | Direct I/O access enable bit |
| io_hi_clear | input | 1 | Clears I/O address bits [31:16] |
| cfg_addr_reg | input | 32 | Configuration address word; bit 31 selects configuration mode |
| win_base | input | 32 | Local window base |
| win_mask | input | 32 | Window mask (inverted size) |
| io_remap | input | 32 | I/O remap base |
| lb_valid | input | 1 | Local word valid, held until lb_ready |
| lb_write | input | 1 | Local write when 1 |
| lb_last | input | 1 | Last word of a burst |
| lb_addr | input | 32 | Local address |
| lb_be | input | 4 | Local byte enables |
| lb_wdata | input | 32 | Local write data |
| lb_ready | output | 1 | Local word done pulse |
| lb_rdata | output | 32 | Read data to local bus |
| pci_req | output | 1 | PCI transaction request |
| pci_cmd | output | 4 | PCI command code |
| pci_addr | output | 32 | PCI address phase value |
| pci_be | output | 4 | PCI byte enables |
| pci_wdata | output | 32 | PCI write data |
| pci_ack | input | 1 | Transaction done from PCI engine |
| pci_rdata | input | 32 | Read data from PCI engine |

## Verification
The hardest situation to reach is a burst whose later words must ignore lb_addr. The block also has to wait out a posted write that is still occupying the PCI side. To create this, the bench drives multi-word bursts and deliberately puts garbage on lb_addr after the first word. It also lets the PCI responder hold each request for several cycles. As a result, the next word's claim collides with an outstanding transaction and with the tail of a ready pulse. For the IDSEL decode, the bench uses device numbers 10, 20 and 25, which cover the middle case, the highest legal bit and the overflow case.

// File: rtl/iocfg_pkg.sv
package iocfg_pkg;
  parameter int unsigned AW   = 32;
  parameter int unsigned DW   = 32;
  parameter int unsigned BEW  = DW / 8;
  parameter int unsigned BIXW = $clog2(BEW);
  parameter int unsigned CMDW = 4;

  // Bit 0 of every code is the write flag; the sequencer relies on this.
  typedef enum logic [CMDW-1:0] {
    CMD_IO_RD  = 4'b0010,
    CMD_IO_WR  = 4'b0011,
    CMD_CFG_RD = 4'b1010,
    CMD_CFG_WR = 4'b1011
  } pci_cmd_e;

  typedef struct packed {
    logic [CMDW-1:0] cmd;
    logic [AW-1:0]   addr;
    logic [BEW-1:0]  be;
    logic [DW-1:0]   data;
  } pci_xact_t;

  function automatic logic [BIXW-1:0] lowest_be(input logic [BEW-1:0] be);
    logic [BIXW-1:0] idx;
    idx = '0;
    for (int i = BEW - 1; i >= 0; i--) begin
      if (be[i]) idx = BIXW'(i);
    end
    return idx;
  endfunction
endpackage

// File: rtl/iocfg_win_dec.sv
module iocfg_win_dec
  import iocfg_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] mask,
  output logic          hit
);
  logic [AW-1:0] diff;

  always_comb begin
    diff = (addr ^ base) & mask;
    hit  = (diff == '0);
  end
endmodule

// File: rtl/iocfg_addr_gen.sv
module iocfg_addr_gen
  import iocfg_pkg::*;
#(
  parameter int unsigned DEV_LSB    = 11,
  parameter int unsigned DEVW       = 5,
  parameter int unsigned HI_CLR_LSB = 16,
  parameter int unsigned T1_KEEP    = 24
) (
  input  logic [AW-1:0]   cfg_reg,
  input  logic [AW-1:0]   word_addr,
  input  logic [AW-1:0]   remap,
  input  logic [AW-1:0]   mask,
  input  logic            hi_clear,
  input  logic            write,
  input  logic [BEW-1:0]  be,
  output logic [AW-1:0]   addr,
  output logic [CMDW-1:0] cmd
);
  localparam int unsigned NSEL       = AW - DEV_LSB;
  localparam int unsigned CFG_EN_BIT = AW - 1;

  logic [DEVW-1:0] dev;
  logic [NSEL-1:0] idsel;
  logic [AW-1:0]   io_addr;
  logic [AW-1:0]   t0_addr;
  logic [AW-1:0]   t1_addr;
  logic            cfg_mode;
  logic            type1;
  logic            unused_cfg;

  assign dev        = cfg_reg[DEV_LSB +: DEVW];
  assign cfg_mode   = cfg_reg[CFG_EN_BIT];
  assign type1      = (cfg_reg[1:0] != 2'b00);
  assign unused_cfg = ^cfg_reg[CFG_EN_BIT-1:T1_KEEP];

  // One comparator per selectable AD line; numbers past the top select none.
  genvar gi;
  generate
    for (gi = 0; gi < NSEL; gi++) begin : g_idsel
      assign idsel[gi] = (dev == DEVW'(gi));
    end
  endgenerate

  always_comb begin
    io_addr = (remap & mask) | (word_addr & ~mask);
    if (hi_clear) io_addr[AW-1:HI_CLR_LSB] = '0;
    io_addr[BIXW-1:0] = lowest_be(be);

    t0_addr = {idsel, cfg_reg[DEV_LSB-1:0]};

    t1_addr = '0;
    t1_addr[T1_KEEP-1:0] = cfg_reg[T1_KEEP-1:0];

    if (cfg_mode) begin
      addr = type1 ? t1_addr : t0_addr;
      cmd  = write ? CMD_CFG_WR : CMD_CFG_RD;
    end else begin
      addr = io_addr;
      cmd  = write ? CMD_IO_WR : CMD_IO_RD;
    end
  end
endmodule

// File: rtl/iocfg_seq.sv
module iocfg_seq
  import iocfg_pkg::*;
#(
  parameter int unsigned STEP = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en_all,
  input  logic           hit,
  input  logic           lb_valid,
  input  logic           lb_write,
  input  logic           lb_last,
  input  logic [AW-1:0]  lb_addr,
  output logic [AW-1:0]  word_addr,
  input  pci_xact_t      nxt,
  output logic           lb_ready,
  output logic [DW-1:0]  lb_rdata,
  output logic           pci_req,
  output pci_xact_t      pkt,
  input  logic           pci_ack,
  input  logic [DW-1:0]  pci_rdata
);
  logic          req_q, req_d;
  logic          rdy_q, rdy_d;
  logic          in_burst_q, in_burst_d;
  logic [AW-1:0] next_addr_q;
  pci_xact_t     pkt_q;
  logic [DW-1:0] rdata_q;
  logic          accept;
  logic          rd_done;

  always_comb begin
    word_addr  = in_burst_q ? next_addr_q : lb_addr;
    accept     = lb_valid && !req_q && !rdy_q && en_all && (in_burst_q || hit);
    rd_done    = req_q && pci_ack && !pkt_q.cmd[0];
    req_d      = accept || (req_q && !pci_ack);
    rdy_d      = (accept && lb_write) || rd_done;
    in_burst_d = accept ? !lb_last : in_burst_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q       <= 1'b0;
      rdy_q       <= 1'b0;
      in_burst_q  <= 1'b0;
      next_addr_q <= '0;
      pkt_q       <= '0;
      rdata_q     <= '0;
    end else begin
      req_q      <= req_d;
      rdy_q      <= rdy_d;
      in_burst_q <= in_burst_d;
      if (accept) begin
        next_addr_q <= word_addr + AW'(STEP);
        pkt_q       <= nxt;
      end
      if (rd_done) rdata_q <= pci_rdata;
    end
  end

  assign lb_ready = rdy_q;
  assign lb_rdata = rdata_q;
  assign pci_req  = req_q;
  assign pkt      = pkt_q;

  // R2: with the enables off, an idle sequencer stays idle
  a_r2_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_all && !req_q) |=> !req_q);
  // R12: request and its fields hold until acknowledged
  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !pci_ack) |=> (req_q && $stable(pkt_q)));
  // R9: a write is acknowledged as soon as its request appears
  a_r9_posted: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(req_q) && pkt_q.cmd[0]) |-> rdy_q);
  // R9: ready is a single-cycle pulse
  a_r9_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rdy_q |=> !rdy_q);
  // R10: no ready while a read is outstanding
  a_r10_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !pkt_q.cmd[0]) |-> !rdy_q);
  // R10: read data delivered the cycle after the acknowledge
  a_r10_data: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && pci_ack && !pkt_q.cmd[0]) |=> (rdy_q && rdata_q == $past(pci_rdata)));
endmodule

// File: rtl/iocfg_bridge.sv
module iocfg_bridge
  import iocfg_pkg::*;
#(
  parameter int unsigned DEV_LSB    = 11,
  parameter int unsigned HI_CLR_LSB = 16,
  parameter int unsigned T1_KEEP    = 24,
  parameter int unsigned WORD_STEP  = BEW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_master,
  input  logic            en_io_space,
  input  logic            en_dm_io,
  input  logic            io_hi_clear,
  input  logic [AW-1:0]   cfg_addr_reg,
  input  logic [AW-1:0]   win_base,
  input  logic [AW-1:0]   win_mask,
  input  logic [AW-1:0]   io_remap,
  input  logic            lb_valid,
  input  logic            lb_write,
  input  logic            lb_last,
  input  logic [AW-1:0]   lb_addr,
  input  logic [BEW-1:0]  lb_be,
  input  logic [DW-1:0]   lb_wdata,
  output logic            lb_ready,
  output logic [DW-1:0]   lb_rdata,
  output logic            pci_req,
  output logic [CMDW-1:0] pci_cmd,
  output logic [AW-1:0]   pci_addr,
  output logic [BEW-1:0]  pci_be,
  output logic [DW-1:0]   pci_wdata,
  input  logic            pci_ack,
  input  logic [DW-1:0]   pci_rdata
);
  logic [1:0]      rst_sync_q;
  logic            rst_sn;
  logic            hit;
  logic            en_all;
  logic [AW-1:0]   word_addr;
  logic [AW-1:0]   gen_addr;
  logic [CMDW-1:0] gen_cmd;
  pci_xact_t       nxt;
  pci_xact_t       pkt;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  assign en_all = en_master && en_io_space && en_dm_io;

  iocfg_win_dec u_dec (
    .addr (lb_addr),
    .base (win_base),
    .mask (win_mask),
    .hit  (hit)
  );

  iocfg_addr_gen #(
    .DEV_LSB    (DEV_LSB),
    .DEVW       (5),
    .HI_CLR_LSB (HI_CLR_LSB),
    .T1_KEEP    (T1_KEEP)
  ) u_agen (
    .cfg_reg   (cfg_addr_reg),
    .word_addr (word_addr),
    .remap     (io_remap),
    .mask      (win_mask),
    .hi_clear  (io_hi_clear),
    .write     (lb_write),
    .be        (lb_be),
    .addr      (gen_addr),
    .cmd       (gen_cmd)
  );

  always_comb begin
    nxt.cmd  = gen_cmd;
    nxt.addr = gen_addr;
    nxt.be   = lb_be;
    nxt.data = lb_wdata;
  end

  iocfg_seq #(.STEP(WORD_STEP)) u_seq (
    .clk       (clk),
    .rst_n     (rst_sn),
    .en_all    (en_all),
    .hit       (hit),
    .lb_valid  (lb_valid),
    .lb_write  (lb_write),
    .lb_last   (lb_last),
    .lb_addr   (lb_addr),
    .word_addr (word_addr),
    .nxt       (nxt),
    .lb_ready  (lb_ready),
    .lb_rdata  (lb_rdata),
    .pci_req   (pci_req),
    .pkt       (pkt),
    .pci_ack   (pci_ack),
    .pci_rdata (pci_rdata)
  );

  assign pci_cmd   = pkt.cmd;
  assign pci_addr  = pkt.addr;
  assign pci_be    = pkt.be;
  assign pci_wdata = pkt.data;

  // R5: a Type 0 address never selects more than one device line
  a_r5_idsel_onehot: assert property (@(posedge clk) disable iff (!rst_sn)
    (pci_req && pci_cmd[3] && pci_addr[1:0] == 2'b00) |-> $onehot0(pci_addr[AW-1:DEV_LSB]));
  // R6: a Type 1 address keeps its top byte clear
  a_r6_top_zero: assert property (@(posedge clk) disable iff (!rst_sn)
    (pci_req && pci_cmd[3] && pci_addr[1:0] != 2'b00) |-> (pci_addr[AW-1:T1_KEEP] == '0));
  // R8: byte enables of a new request are those of the word just claimed
  a_r8_be_pass: assert property (@(posedge clk) disable iff (!rst_sn)
    $rose(pci_req) |-> (pci_be == $past(lb_be)));
endmodule

// File: tb/sim_iocfg_bridge.sv
module sim_iocfg_bridge;
  localparam int RESP_DLY = 4;
  localparam logic [31:0] BASE  = 32'h4000_0000;
  localparam logic [31:0] MASK  = 32'hFFF0_0000;
  localparam logic [31:0] REMAP = 32'h1230_0000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en_master, en_io_space, en_dm_io, io_hi_clear;
  logic [31:0] cfg_addr_reg, win_base, win_mask, io_remap;
  logic        lb_valid, lb_write, lb_last;
  logic [31:0] lb_addr, lb_wdata;
  logic [3:0]  lb_be;
  logic        lb_ready;
  logic [31:0] lb_rdata;
  logic        pci_req;
  logic [3:0]  pci_cmd;
  logic [31:0] pci_addr, pci_wdata;
  logic [3:0]  pci_be;
  logic        pci_ack;
  logic [31:0] pci_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [3:0]  qc[$];
  logic [31:0] qa[$];
  logic [3:0]  qb[$];
  logic [31:0] qd[$];
  string       qt[$];

  always #2 clk = ~clk;

  iocfg_bridge u0 (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] io_exp(input logic [31:0] a, input logic [3:0] be, input bit clr);
    logic [31:0] r;
    r = (REMAP & MASK) | (a & ~MASK);
    if (clr) r[31:16] = '0;
    r[1:0] = 2'd0;
    for (int i = 3; i >= 0; i--) if (be[i]) r[1:0] = 2'(i);
    return r;
  endfunction

  function automatic logic [31:0] t0_exp(input logic [31:0] rg);
    int d;
    logic [31:0] r;
    d = int'(rg[15:11]);
    r = {21'd0, rg[10:0]};
    if (d <= 20) r[d + 11] = 1'b1;
    return r;
  endfunction

  // PCI-side responder and scoreboard monitor
  initial begin
    pci_ack = 1'b0;
    pci_rdata = '0;
    forever begin
      @(negedge clk);
      if (pci_req) begin
        logic [31:0] a0;
        bit held;
        a0 = pci_addr;
        if (qc.size() == 0) begin
          chk(1'b0, "R1/R2 unexpected request", pci_addr, 32'h0);
        end else begin
          logic [3:0] ec; logic [31:0] ea; logic [3:0] eb; logic [31:0] ed; string t;
          ec = qc.pop_front(); ea = qa.pop_front(); eb = qb.pop_front();
          ed = qd.pop_front(); t = qt.pop_front();
          chk(pci_cmd == ec, {t, " cmd"}, {28'd0, pci_cmd}, {28'd0, ec});
          chk(pci_addr == ea, {t, " addr"}, pci_addr, ea);
          chk(pci_be == eb, {"R8 be ", t}, {28'd0, pci_be}, {28'd0, eb});
          if (ec[0]) chk(pci_wdata == ed, {"R8 wdata ", t}, pci_wdata, ed);
        end
        pci_rdata = ~a0;
        held = 1'b1;
        for (int k = 0; k < RESP_DLY; k++) begin
          @(negedge clk);
          if (!pci_req || pci_addr != a0) held = 1'b0;
        end
        chk(held, "R12 request held until ack", pci_addr, a0);
        pci_ack = 1'b1;
        @(negedge clk);
        pci_ack = 1'b0;
      end
    end
  end

  task automatic xfer(input bit wr, input logic [31:0] a, input logic [3:0] be,
                      input logic [31:0] d, input bit last,
                      input logic [3:0] ecmd, input logic [31:0] eaddr, input string tag);
    int n;
    if (!wr) while (pci_req) @(negedge clk);
    qc.push_back(ecmd); qa.push_back(eaddr); qb.push_back(be); qd.push_back(d); qt.push_back(tag);
    lb_valid = 1'b1; lb_write = wr; lb_addr = a; lb_be = be; lb_wdata = d; lb_last = last;
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!lb_ready && n < 60);
    chk(lb_ready, {tag, " ready seen"}, 32'(n), 32'd0);
    if (wr) begin
      chk(pci_req && !pci_ack, {"R9 write posted ", tag}, {31'd0, pci_req}, 32'd1);
    end else begin
      chk(!pci_req && n > RESP_DLY, {"R10 read held off ", tag}, 32'(n), 32'(RESP_DLY + 2));
      chk(lb_rdata == ~eaddr, {"R10 read data ", tag}, lb_rdata, ~eaddr);
    end
    lb_valid = 1'b0;
  endtask

  task automatic noxfer(input logic [31:0] a, input string tag);
    bit quiet;
    while (pci_req) @(negedge clk);
    quiet = 1'b1;
    lb_valid = 1'b1; lb_write = 1'b1; lb_addr = a; lb_be = 4'hF; lb_last = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      if (lb_ready || pci_req) quiet = 1'b0;
    end
    chk(quiet, tag, {31'd0, pci_req}, 32'd0);
    lb_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    en_master = 1'b0; en_io_space = 1'b0; en_dm_io = 1'b0; io_hi_clear = 1'b0;
    cfg_addr_reg = '0; win_base = BASE; win_mask = MASK; io_remap = REMAP;
    lb_valid = 1'b0; lb_write = 1'b0; lb_last = 1'b1; lb_addr = '0; lb_be = '0; lb_wdata = '0;
    repeat (3) @(negedge clk);
    chk(!pci_req && !lb_ready, "R12 reset state", {30'd0, pci_req, lb_ready}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!pci_req && !lb_ready, "R12 idle after reset", {30'd0, pci_req, lb_ready}, 32'd0);

    // R2: each enable alone missing
    en_master = 1'b0; en_io_space = 1'b1; en_dm_io = 1'b1;
    noxfer(32'h4000_1000, "R2 master enable off");
    en_master = 1'b1; en_io_space = 1'b0;
    noxfer(32'h4000_1000, "R2 io space enable off");
    en_io_space = 1'b1; en_dm_io = 1'b0;
    noxfer(32'h4000_1000, "R2 direct io enable off");
    en_dm_io = 1'b1;

    // R3 I/O write and read
    xfer(1, 32'h4001_2340, 4'b1100, 32'hDEAD_BEEF, 1, 4'b0011, io_exp(32'h4001_2340, 4'b1100, 0), "R3 io write");
    xfer(0, 32'h400A_BCD4, 4'b0001, 32'h0, 1, 4'b0010, io_exp(32'h400A_BCD4, 4'b0001, 0), "R3 io read");
    xfer(0, 32'h400F_FFFC, 4'b1000, 32'h0, 1, 4'b0010, 32'h123F_FFFF, "R3 io read top of window");

    // R1 window miss, then a hit still works
    noxfer(32'h5000_0000, "R1 window miss");
    noxfer(32'h4010_0000, "R1 just past window");

    // R4 upper half cleared
    io_hi_clear = 1'b1;
    xfer(1, 32'h4001_2340, 4'b1111, 32'h1111_2222, 1, 4'b0011, 32'h0000_2340, "R4 io high clear");
    io_hi_clear = 1'b0;

    // R11 I/O write burst; later lb_addr is garbage
    xfer(1, 32'h4000_0100, 4'b1111, 32'hA000_0001, 0, 4'b0011, 32'h1230_0100, "R11 burst w0");
    xfer(1, 32'h0BAD_0000, 4'b1111, 32'hA000_0002, 0, 4'b0011, 32'h1230_0104, "R11 burst w1");
    xfer(1, 32'h0BAD_0000, 4'b0110, 32'hA000_0003, 1, 4'b0011, 32'h1230_0109, "R11 burst w2");
    // R11 read burst
    xfer(0, 32'h4000_0200, 4'b1111, 32'h0, 0, 4'b0010, 32'h1230_0200, "R11 rburst r0");
    xfer(0, 32'h0BAD_0000, 4'b1111, 32'h0, 1, 4'b0010, 32'h1230_0204, "R11 rburst r1");

    // R5/R7 Type 0: device 10, register 4 -> AD21, low 0x010
    cfg_addr_reg = 32'h8000_5010;
    xfer(1, 32'h4000_0000, 4'b1111, 32'h5555_0000, 1, 4'b1011, 32'h0020_0010, "R5 R7 type0 dev10 write");
    chk(t0_exp(32'h8000_5010) == 32'h0020_0010, "R5 model dev10", t0_exp(32'h8000_5010), 32'h0020_0010);
    xfer(0, 32'h4000_0000, 4'b0011, 32'h0, 1, 4'b1010, 32'h0020_0010, "R5 R7 type0 dev10 read");
    cfg_addr_reg = 32'h8000_0000 | (32'd20 << 11) | 32'h0000_0308;
    xfer(0, 32'h4000_0000, 4'b1111, 32'h0, 1, 4'b1010, t0_exp(cfg_addr_reg), "R5 type0 dev20 top bit");
    cfg_addr_reg = 32'h8000_0000 | (32'd25 << 11) | 32'h0000_0008;
    xfer(1, 32'h4000_0000, 4'b1111, 32'h7777_0000, 1, 4'b1011, 32'h0000_0008, "R5 type0 dev25 no idsel");

    // R6 Type 1
    cfg_addr_reg = 32'h80AB_CD05;
    xfer(0, 32'h4000_0000, 4'b1111, 32'h0, 1, 4'b1010, 32'h00AB_CD05, "R6 type1 read");
    // R11 config burst: same address each word
    xfer(1, 32'h4000_0000, 4'b1111, 32'hC0C0_0001, 0, 4'b1011, 32'h00AB_CD05, "R11 cfg burst w0");
    xfer(1, 32'h0BAD_0000, 4'b0001, 32'hC0C0_0002, 1, 4'b1011, 32'h00AB_CD05, "R11 cfg burst w1");

    while (pci_req || qc.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(!pci_req && !lb_ready, "R12 idle at end", {30'd0, pci_req, lb_ready}, 32'd0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule